// File: doc/BRIEF.md
# Serial Conversion Result Framer

This block models the digital serial output of a 12-bit sampling converter, as a SPI, QSPI or Microwire host sees it. When the select line goes low, the block captures the conversion result from its parallel input. The first serial clock fall after that opens a frame. The frame holds one leading-zero slot marked by a strobe, then the result bits MSB first, then zeros until the host deselects. The block does not model the analog sampling or the bit-by-bit decisions. The result arrives ready-made on a 12-bit input.

All inputs are synchronous to a fast system clock `clk`. The block finds the serial clock edges by comparing each input with its registered value. State therefore changes on the `clk` edge at which a serial clock fall is first seen. Each of the three serial outputs has its own enable output, which stands in for a three-state pin. A separate active-low enable input controls the clock mirror and the strobe. A second input chooses between a free-running clock mirror and one that only toggles during the frame.

Top module: `adc_serial_framer`

## Requirements
- R1: After reset, and in every cycle where `sel_n` is high, `ser_data_oe`, `ser_clk_oe` and `strobe_oe` are all 0.
- R2: `ser_data_oe` stays 0 after `sel_n` falls until a fall of `ser_clk` is seen in a later `clk` cycle. A `ser_clk` fall in the same `clk` cycle as the `sel_n` fall does not open the frame.
- R3: Slot 0 runs from the frame-opening fall to the next fall. In slot 0, `ser_data` is 0 and `strobe` is 1. `strobe` is 0 in every other slot.
- R4: Slots 1 to 12 carry result bits 11 down to 0 (MSB first). Each bit appears one `clk` edge after the `ser_clk` fall that opens its slot, and it holds across the following `ser_clk` rise.
- R5: The result is captured on the `clk` edge where `sel_n` is seen falling. Later changes to `result` do not alter the frame.
- R6: From slot 13 on, `ser_data` is 0 for as long as `sel_n` stays low. Further `ser_clk` falls never restart the frame or raise `strobe` again.
- R7: While `sel_n` is low, `ser_clk_oe` and `strobe_oe` are 1 when `aux_en_n` is 0 and are 0 when `aux_en_n` is 1. `ser_data_oe` does not depend on `aux_en_n`.
- R8: With `clk_free` high, `ser_clk_out` follows `ser_clk` at any time, including before the frame opens. With `clk_free` low, `ser_clk_out` rises only in slots 0 to 12, which is 13 pulses per frame.
- R9: When `sel_n` rises during a frame, the frame ends, even if a `ser_clk` fall lands in the same cycle. The next `sel_n` fall captures a new result and starts again at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low select from the host |
| ser_clk | input | 1 | Serial clock from the host |
| aux_en_n | input | 1 | Active-low enable for the clock mirror and the strobe |
| clk_free | input | 1 | 1: clock mirror runs freely; 0: clock mirror runs only during the frame |
| result | input | 12 | Conversion result, captured when select falls |
| ser_data | output | 1 | Serial data value |
| ser_data_oe | output | 1 | Drive enable for ser_data |
| ser_clk_out | output | 1 | Mirrored serial clock |
| ser_clk_oe | output | 1 | Drive enable for ser_clk_out |
| strobe | output | 1 | Frame-start strobe |
| strobe_oe | output | 1 | Drive enable for strobe |

## Verification
Two pairs of events can fall in the same `clk` cycle. The first is the select fall and the serial clock fall. The bench drives both at the same edge and checks that the data enable stays low for a whole serial period and that the frame opens only on the next fall. The second is deselect and a serial clock fall during a running frame. The bench lowers both together and checks that every enable drops at once. A following select must then start a clean frame with the leading zero and the strobe.

// File: rtl/adc_frm_pkg.sv
package adc_frm_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ARMED = 2'd1,
    PH_RUN   = 2'd2
  } phase_e;

  // index of the first padding slot: lead slot 0, data slots 1..w
  function automatic int unsigned pad_index(input int unsigned w);
    return w + 1;
  endfunction

  // counter width able to hold the padding index
  function automatic int unsigned slot_bits(input int unsigned w);
    return $clog2(pad_index(w) + 1);
  endfunction

endpackage

// File: rtl/adc_frm_edge.sv
module adc_frm_edge #(
  parameter int unsigned      N       = 2,
  parameter logic [N-1:0]     RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sig,
  output logic [N-1:0] fall
);

  logic [N-1:0] prev_q;

  generate
    for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q[i] <= RST_VAL[i];
        else        prev_q[i] <= sig[i];
      end
      assign fall[i] = prev_q[i] & ~sig[i];
    end
  endgenerate

endmodule

// File: rtl/adc_frm_seq.sv
module adc_frm_seq
  import adc_frm_pkg::*;
#(
  parameter int unsigned RES_W = 12,
  localparam int unsigned SLOT_W = slot_bits(RES_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              sel_fall,
  input  logic              sclk_fall,
  input  logic [RES_W-1:0]  result,
  output logic              run,
  output logic              in_conv,
  output logic              lead_slot,
  output logic              data_bit
);

  localparam logic [SLOT_W-1:0] PAD_SLOT  = SLOT_W'(pad_index(RES_W));
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(RES_W);

  phase_e             phase_q;
  logic [SLOT_W-1:0]  slot_q;
  logic [RES_W-1:0]   shreg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      slot_q  <= '0;
      shreg_q <= '0;
    end else if (sel_n) begin
      phase_q <= PH_IDLE;
      slot_q  <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (sel_fall) begin
            phase_q <= PH_ARMED;
            shreg_q <= result;
          end
        end
        PH_ARMED: begin
          if (sclk_fall) begin
            phase_q <= PH_RUN;
            slot_q  <= '0;
          end
        end
        PH_RUN: begin
          if (sclk_fall) begin
            if (slot_q != PAD_SLOT) slot_q <= slot_q + 1'b1;
            if (slot_q != '0)       shreg_q <= {shreg_q[RES_W-2:0], 1'b0};
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign run       = (phase_q == PH_RUN);
  assign in_conv   = run && (slot_q <= LAST_SLOT);
  assign lead_slot = run && (slot_q == '0);
  assign data_bit  = (run && (slot_q != '0)) ? shreg_q[RES_W-1] : 1'b0;

  AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |=> (phase_q == PH_IDLE)); // R1
  AST_START_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> ($past(sclk_fall) && $past(phase_q) == PH_ARMED)); // R2
  AST_STROBE_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (lead_slot && sclk_fall) |=> !lead_slot); // R3
  AST_SLOT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q <= PAD_SLOT); // R6
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> (slot_q >= $past(slot_q))); // R6
  AST_PAD_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (run && slot_q == PAD_SLOT) |-> (shreg_q == '0)); // R6

endmodule

// File: rtl/adc_frm_pins.sv
module adc_frm_pins (
  input  logic sel_n,
  input  logic ser_clk,
  input  logic aux_en_n,
  input  logic clk_free,
  input  logic run,
  input  logic in_conv,
  input  logic lead_slot,
  input  logic data_bit,
  output logic ser_data,
  output logic ser_data_oe,
  output logic ser_clk_out,
  output logic ser_clk_oe,
  output logic strobe,
  output logic strobe_oe
);

  logic selected;
  logic aux_on;

  assign selected    = ~sel_n;
  assign aux_on      = selected & ~aux_en_n;

  assign ser_data    = data_bit;
  assign ser_data_oe = selected & run;
  assign ser_clk_out = ser_clk & (clk_free | in_conv);
  assign ser_clk_oe  = aux_on;
  assign strobe      = lead_slot;
  assign strobe_oe   = aux_on;

endmodule

// File: rtl/adc_serial_framer.sv
module adc_serial_framer #(
  parameter int unsigned RES_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_n,
  input  logic             ser_clk,
  input  logic             aux_en_n,
  input  logic             clk_free,
  input  logic [RES_W-1:0] result,
  output logic             ser_data,
  output logic             ser_data_oe,
  output logic             ser_clk_out,
  output logic             ser_clk_oe,
  output logic             strobe,
  output logic             strobe_oe
);

  logic [1:0] falls;
  logic       sel_fall;
  logic       sclk_fall;
  logic       run;
  logic       in_conv;
  logic       lead_slot;
  logic       data_bit;

  adc_frm_edge #(
    .N       (2),
    .RST_VAL (2'b10)
  ) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .sig   ({sel_n, ser_clk}),
    .fall  (falls)
  );

  assign sel_fall  = falls[1];
  assign sclk_fall = falls[0];

  adc_frm_seq #(
    .RES_W (RES_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_n     (sel_n),
    .sel_fall  (sel_fall),
    .sclk_fall (sclk_fall),
    .result    (result),
    .run       (run),
    .in_conv   (in_conv),
    .lead_slot (lead_slot),
    .data_bit  (data_bit)
  );

  adc_frm_pins u_pins (
    .sel_n       (sel_n),
    .ser_clk     (ser_clk),
    .aux_en_n    (aux_en_n),
    .clk_free    (clk_free),
    .run         (run),
    .in_conv     (in_conv),
    .lead_slot   (lead_slot),
    .data_bit    (data_bit),
    .ser_data    (ser_data),
    .ser_data_oe (ser_data_oe),
    .ser_clk_out (ser_clk_out),
    .ser_clk_oe  (ser_clk_oe),
    .strobe      (strobe),
    .strobe_oe   (strobe_oe)
  );

  AST_DATA_QUIET_UNTIL_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_data_oe) |-> $past(sclk_fall)); // R2
  AST_LEAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    lead_slot |-> !ser_data); // R3
  AST_GATED_MIRROR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_free && !run) |-> !ser_clk_out); // R8

endmodule

// File: tb/test_adc_serial_framer.sv
module test_adc_serial_framer;

  localparam int W = 12;
  localparam int H = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sel_n = 1'b1;
  logic         ser_clk = 1'b1;
  logic         aux_en_n = 1'b0;
  logic         clk_free = 1'b0;
  logic [W-1:0] result = '0;
  logic ser_data, ser_data_oe, ser_clk_out, ser_clk_oe, strobe, strobe_oe;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  adc_serial_framer #(.RES_W(W)) i_adc_serial_framer (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .ser_clk(ser_clk),
    .aux_en_n(aux_en_n), .clk_free(clk_free), .result(result),
    .ser_data(ser_data), .ser_data_oe(ser_data_oe),
    .ser_clk_out(ser_clk_out), .ser_clk_oe(ser_clk_oe),
    .strobe(strobe), .strobe_oe(strobe_oe)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit expect_bit(input logic [W-1:0] v, input int k);
    if (k >= 1 && k <= W) return v[W-k];
    return 1'b0;
  endfunction

  task automatic t_reset;
    chk(ser_data_oe == 0 && ser_clk_oe == 0 && strobe_oe == 0, "R1 reset enables",
        {ser_data_oe, ser_clk_oe, strobe_oe}, 0);
  endtask

  // one full frame; select is low on return
  task automatic t_frame(input logic [W-1:0] v, input bit free, input bit aux_n);
    int pulses;
    pulses   = 0;
    clk_free = free;
    aux_en_n = aux_n;
    result   = v;
    ser_clk  = 1'b1;
    tick(2);
    sel_n = 1'b0;
    tick(3);
    chk(ser_data_oe == 0, "R2 data quiet before first fall", ser_data_oe, 0);
    chk(ser_clk_out == free, "R8 mirror before frame", ser_clk_out, free);
    chk(ser_clk_oe == !aux_n && strobe_oe == !aux_n, "R7 aux enables",
        {ser_clk_oe, strobe_oe}, {2{!aux_n}});
    result = ~v;                       // R5: must not reach the frame
    for (int k = 0; k < 20; k++) begin
      ser_clk = 1'b0;
      tick(2);
      chk(strobe == (k == 0), "R3 strobe slot", strobe, k == 0);
      chk(ser_data_oe == 1, "R7 data enable follows frame", ser_data_oe, 1);
      tick(2);
      chk(ser_data == expect_bit(v, k), (k == 0) ? "R3 lead zero" :
          (k <= W) ? "R4 R5 result bit" : "R6 padding", ser_data, expect_bit(v, k));
      ser_clk = 1'b1;
      tick(1);
      if (ser_clk_out) pulses++;
      chk(ser_data == expect_bit(v, k), "R4 bit holds over rise", ser_data, expect_bit(v, k));
      tick(H - 1);
    end
    chk(pulses == (free ? 20 : W + 1), "R8 mirror pulses", pulses, free ? 20 : W + 1);
  endtask

  task automatic t_deselect;
    sel_n = 1'b1;
    tick(1);
    chk(ser_data_oe == 0 && ser_clk_oe == 0 && strobe_oe == 0, "R1 deselect enables",
        {ser_data_oe, ser_clk_oe, strobe_oe}, 0);
  endtask

  // select fall and serial clock fall in the same clk cycle
  task automatic t_same_cycle_start(input logic [W-1:0] v);
    clk_free = 1'b0;
    aux_en_n = 1'b0;
    result   = v;
    ser_clk  = 1'b1;
    tick(2);
    sel_n   = 1'b0;
    ser_clk = 1'b0;
    tick(H);
    chk(ser_data_oe == 0, "R2 coincident fall ignored", ser_data_oe, 0);
    ser_clk = 1'b1;
    tick(H);
    ser_clk = 1'b0;
    tick(2);
    chk(ser_data_oe == 1 && strobe == 1, "R2 frame on next fall", {ser_data_oe, strobe}, 3);
    tick(2);
    chk(ser_data == 0, "R3 lead zero after late start", ser_data, 0);
    ser_clk = 1'b1;
    tick(H);
    ser_clk = 1'b0;
    tick(2);
    chk(ser_data == v[W-1] && strobe == 0, "R4 MSB after late start",
        {ser_data, strobe}, {v[W-1], 1'b0});
    ser_clk = 1'b1;
    tick(H);
    t_deselect();
  endtask

  // deselect together with a serial clock fall in mid-frame, then restart
  task automatic t_abort(input logic [W-1:0] v1, input logic [W-1:0] v2);
    clk_free = 1'b0;
    result   = v1;
    ser_clk  = 1'b1;
    tick(2);
    sel_n = 1'b0;
    tick(2);
    for (int k = 0; k < 5; k++) begin
      ser_clk = 1'b0; tick(H);
      ser_clk = 1'b1; tick(H);
    end
    sel_n   = 1'b1;
    ser_clk = 1'b0;
    tick(1);
    chk(ser_data_oe == 0 && strobe_oe == 0 && ser_clk_oe == 0, "R9 abort enables",
        {ser_data_oe, ser_clk_oe, strobe_oe}, 0);
    tick(2);
    chk(ser_clk_out == 0, "R9 mirror quiet after abort", ser_clk_out, 0);
    t_frame(v2, 1'b0, 1'b0);           // R9 fresh frame with new capture
    t_deselect();
  endtask

  initial begin
    tick(3);
    t_reset();
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_frame(12'hA5C, 1'b0, 1'b0);
    t_deselect();
    t_frame(12'h801, 1'b1, 1'b0);
    t_deselect();
    t_frame(12'hFFF, 1'b0, 1'b1);
    t_deselect();
    t_frame(12'h000, 1'b1, 1'b1);
    t_deselect();
    for (int r = 0; r < 4; r++) begin
      t_frame(W'($urandom), r[0], 1'b0);
      t_deselect();
    end
    t_same_cycle_start(12'hB37);
    t_abort(12'h3C3, 12'h96E);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule